// File: doc/BRIEF.md
# Zero-Turnaround Flow-Through Burst SRAM

This block is a synchronous single-port SRAM. Reads and writes may follow each other on every clock with no idle cycle between them. A command cycle registers the address, the operation and the byte selects. Read data then appears in the cycle after that edge, taken combinationally from the registered state (flow-through). Write data is sampled one enabled edge after its command cycle, so a read issued in a write's data cycle can never fight the incoming data on the bus. The output drivers are switched off on their own during every write data cycle and every deselected cycle.

One loaded address serves a burst of four beats. A load/advance control picks between taking a new address with a new operation and stepping the burst in progress. The step order is linear or interleaved, chosen by a static mode pin. A clock enable freezes the whole block for a cycle. A sleep pin turns the drivers off and refuses new commands. An asynchronous output enable also gates the drivers. The data bus is split into `din`, `dout` and `dout_oe`.

Top module: `zt_burst_sram`

## Requirements
- R1: A read command captured at an enabled edge (`adv_ld`=0, selected, `wr_en`=0) drives `dout` with the addressed word and raises `dout_oe` in the cycle that follows that edge.
- R2: A write command captured at an enabled edge takes its data from `din` at the next enabled edge. Read and write commands may alternate on consecutive cycles with no idle cycle.
- R3: With `adv_ld`=1 the burst steps its 2-bit beat count by one and keeps the operation already in progress. After the fourth beat the count wraps to the first. An idle (deselected) state stays idle.
- R4: With `mode_ilv`=0 the low two address bits of beat k are (base[1:0] + k) mod 4. The upper bits stay at the base.
- R5: With `mode_ilv`=1 the low two address bits of beat k are base[1:0] XOR k.
- R6: `byte_en[i]` is sampled with each write beat's command cycle and enables byte i (bits 8i+7..8i) of that beat's word. With `byte_en`=0 the word is unchanged.
- R7: `dout_oe` is low in every write data cycle and every deselected cycle.
- R8: A load is a read or a write only when `sel0_n`=0, `sel1`=1 and `sel2_n`=0. Any other combination loads a deselect.
- R9: While `clk_en`=0, no memory word changes, the burst and pipeline state hold, and `dout`/`dout_oe` keep their values.
- R10: `oe`=0 forces `dout_oe` low at once, without waiting for a clock.
- R11: While `sleep`=1, `dout_oe` is low and every enabled edge captures a deselect. A write whose data phase falls on such an edge still completes.
- R12: A read captured at the same edge that commits a write to the same address returns the newly written bytes merged with the old unselected bytes.
- R13: After reset, no operation is in progress, no write is pending and `dout_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| clk_en | input | 1 | Clock qualifier; 0 stalls the block for the cycle |
| addr | input | ADDR_W | Word address for a load |
| sel0_n | input | 1 | Chip select, active low |
| sel1 | input | 1 | Chip select, active high |
| sel2_n | input | 1 | Chip select, active low |
| wr_en | input | 1 | 1 selects write on a load, 0 selects read |
| byte_en | input | BYTES | Per-byte write enables |
| adv_ld | input | 1 | 0 loads a new command, 1 advances the burst |
| mode_ilv | input | 1 | Burst order: 0 linear, 1 interleaved |
| sleep | input | 1 | Power-down: drivers off, no new commands |
| oe | input | 1 | Asynchronous output enable, active high |
| din | input | BYTES*BYTE_W | Write data |
| dout | output | BYTES*BYTE_W | Read data |
| dout_oe | output | 1 | Drive enable for `dout` |

## Verification
The bench builds the block with its defaults: a 64-word array of four 8-bit lanes. That depth is small enough to fill every word through burst writes first, so each later read, in any order, has a known expected value. With four byte lanes the bench can reach partial and empty masks as well as bypass merges where only some lanes come from the new data. The 6-bit address lets bursts start at every low-bit offset in both orders and wrap across an aligned group of four.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  // low two address bits for a burst beat
  function automatic logic [1:0] burst_lo(input logic [1:0] base,
                                          input logic [1:0] beat,
                                          input logic       ilv);
    return ilv ? (base ^ beat) : (base + beat);
  endfunction

endpackage

// File: rtl/zt_burst_ctrl.sv
module zt_burst_ctrl
  import zt_sram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clk_en,
  input  logic              sleep,
  input  logic              adv_ld,
  input  logic              sel_ok,
  input  logic              wr_req,
  input  logic              mode_ilv,
  input  logic [ADDR_W-1:0] addr,
  output op_e               op_d,
  output op_e               op_q,
  output logic [ADDR_W-1:0] eff_d
);

  logic [ADDR_W-1:0] base_q, base_d;
  logic [1:0]        beat_q, beat_d;

  always_comb begin
    op_d   = op_q;
    base_d = base_q;
    beat_d = beat_q;
    if (sleep) begin
      op_d = OP_IDLE;
    end else if (!adv_ld) begin
      base_d = addr;
      beat_d = 2'd0;
      if (sel_ok) op_d = wr_req ? OP_WRITE : OP_READ;
      else        op_d = OP_IDLE;
    end else if (op_q != OP_IDLE) begin
      beat_d = beat_q + 2'd1;
    end
  end

  assign eff_d = {base_d[ADDR_W-1:2], burst_lo(base_d[1:0], beat_d, mode_ilv)};

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q   <= OP_IDLE;
      base_q <= '0;
      beat_q <= '0;
    end else if (clk_en) begin
      op_q   <= op_d;
      base_q <= base_d;
      beat_q <= beat_d;
    end
  end

  // R9: a stalled edge leaves the burst state untouched
  p_stall_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !clk_en |=> $stable(op_q) && $stable(beat_q) && $stable(base_q));

  // R8: a load with any select inactive becomes a deselect
  p_desel_r8: assert property (@(posedge clk) disable iff (rst)
    clk_en && !sleep && !adv_ld && !sel_ok |=> op_q == OP_IDLE);

  // R11: sleep captures only deselects
  p_sleep_idle_r11: assert property (@(posedge clk) disable iff (rst)
    clk_en && sleep |=> op_q == OP_IDLE);

  // R3: an advance in an active burst steps the beat count, wrapping mod 4
  p_beat_step_r3: assert property (@(posedge clk) disable iff (rst)
    clk_en && !sleep && adv_ld && op_q != OP_IDLE |=> beat_q == $past(beat_q) + 2'd1);

endmodule

// File: rtl/zt_write_pipe.sv
module zt_write_pipe #(
  parameter int ADDR_W = 6,
  parameter int BYTES  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clk_en,
  input  logic              load_wr,
  input  logic [ADDR_W-1:0] addr_d,
  input  logic [BYTES-1:0]  mask_d,
  output logic              pend_q,
  output logic              commit,
  output logic [ADDR_W-1:0] waddr,
  output logic [BYTES-1:0]  wmask
);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      waddr  <= '0;
      wmask  <= '0;
    end else if (clk_en) begin
      pend_q <= load_wr;
      waddr  <= addr_d;
      wmask  <= mask_d;
    end
  end

  assign commit = clk_en & pend_q;

  // R2: a write command always leaves a pending data phase behind it
  p_pend_follows_r2: assert property (@(posedge clk) disable iff (rst)
    clk_en && load_wr |=> pend_q && waddr == $past(addr_d));

endmodule

// File: rtl/zt_mem_array.sv
module zt_mem_array #(
  parameter int ADDR_W = 6,
  parameter int BYTES  = 4,
  parameter int BYTE_W = 8
) (
  input  logic                    clk,
  input  logic                    en,
  input  logic [BYTES-1:0]        we,
  input  logic [ADDR_W-1:0]       waddr,
  input  logic [BYTES*BYTE_W-1:0] wdata,
  input  logic [ADDR_W-1:0]       raddr,
  output logic [BYTES*BYTE_W-1:0] rdata
);

  localparam int DEPTH  = 1 << ADDR_W;
  localparam int DATA_W = BYTES * BYTE_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // read-first single clock RAM with byte enables
  always_ff @(posedge clk) begin
    if (en) begin
      for (int b = 0; b < BYTES; b++) begin
        if (we[b]) mem[waddr][b*BYTE_W +: BYTE_W] <= wdata[b*BYTE_W +: BYTE_W];
      end
      rdata <= mem[raddr];
    end
  end

endmodule

// File: rtl/zt_burst_sram.sv
module zt_burst_sram
  import zt_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int BYTES  = 4,
  parameter int BYTE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clk_en,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    sel0_n,
  input  logic                    sel1,
  input  logic                    sel2_n,
  input  logic                    wr_en,
  input  logic [BYTES-1:0]        byte_en,
  input  logic                    adv_ld,
  input  logic                    mode_ilv,
  input  logic                    sleep,
  input  logic                    oe,
  input  logic [BYTES*BYTE_W-1:0] din,
  output logic [BYTES*BYTE_W-1:0] dout,
  output logic                    dout_oe
);

  localparam int DATA_W = BYTES * BYTE_W;

  op_e               op_d, op_q;
  logic [ADDR_W-1:0] eff_d, waddr;
  logic [BYTES-1:0]  wmask, byp_mask_q;
  logic              pend_q, commit, sel_ok, byp_q;
  logic [DATA_W-1:0] ram_q, byp_data_q;

  assign sel_ok = !sel0_n && sel1 && !sel2_n;

  zt_burst_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst(rst), .clk_en(clk_en), .sleep(sleep), .adv_ld(adv_ld),
    .sel_ok(sel_ok), .wr_req(wr_en), .mode_ilv(mode_ilv), .addr(addr),
    .op_d(op_d), .op_q(op_q), .eff_d(eff_d)
  );

  zt_write_pipe #(.ADDR_W(ADDR_W), .BYTES(BYTES)) u_wpipe (
    .clk(clk), .rst(rst), .clk_en(clk_en), .load_wr(op_d == OP_WRITE),
    .addr_d(eff_d), .mask_d(byte_en), .pend_q(pend_q), .commit(commit),
    .waddr(waddr), .wmask(wmask)
  );

  zt_mem_array #(.ADDR_W(ADDR_W), .BYTES(BYTES), .BYTE_W(BYTE_W)) u_mem (
    .clk(clk), .en(clk_en), .we(wmask & {BYTES{commit}}), .waddr(waddr),
    .wdata(din), .raddr(eff_d), .rdata(ram_q)
  );

  // bypass for a read captured on the edge that commits the same word
  always_ff @(posedge clk) begin
    if (rst) begin
      byp_q      <= 1'b0;
      byp_mask_q <= '0;
      byp_data_q <= '0;
    end else if (clk_en) begin
      byp_q      <= commit && (op_d == OP_READ) && (eff_d == waddr);
      byp_mask_q <= wmask;
      byp_data_q <= din;
    end
  end

  for (genvar g = 0; g < BYTES; g++) begin : g_lane
    assign dout[g*BYTE_W +: BYTE_W] = (byp_q && byp_mask_q[g]) ?
                                      byp_data_q[g*BYTE_W +: BYTE_W] :
                                      ram_q[g*BYTE_W +: BYTE_W];
  end

  assign dout_oe = (op_q == OP_READ) && oe && !sleep;

  // R7: drivers never on while write data is due on the bus
  p_no_contention_r7: assert property (@(posedge clk) disable iff (rst)
    pend_q |-> !dout_oe);

  // R13: one cycle after reset nothing is driven and nothing is pending
  p_reset_quiet_r13: assert property (@(posedge clk)
    $past(rst) |-> !pend_q && !dout_oe);

endmodule

// File: tb/tb_zt_burst_sram.sv
module tb_zt_burst_sram;

  localparam int AW = 6;
  localparam int NB = 4;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          clk_en = 1'b1;
  logic [AW-1:0] addr = '0;
  logic          sel0_n = 1'b1, sel1 = 1'b0, sel2_n = 1'b1;
  logic          wr_en = 1'b0;
  logic [NB-1:0] byte_en = '0;
  logic          adv_ld = 1'b0;
  logic          mode_ilv = 1'b0;
  logic          sleep = 1'b0;
  logic          oe = 1'b1;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic          dout_oe;

  zt_burst_sram dut (.*);

  always #2.5 clk = ~clk;

  // reference model
  logic [DW-1:0] ref_mem [1<<AW];
  int            m_op = 0;       // 0 idle, 1 read, 2 write
  logic [AW-1:0] m_base = '0;
  int            m_beat = 0;
  bit            m_pend = 0;
  logic [AW-1:0] m_paddr = '0;
  logic [NB-1:0] m_pmask = '0;
  logic [DW-1:0] m_rd = '0;

  int    vecs = 0, fails = 0;
  string cur_req = "R13";
  bit    done = 0;

  function automatic logic [AW-1:0] m_eff();
    logic [1:0] lo;
    lo = mode_ilv ? (m_base[1:0] ^ 2'(m_beat)) : (m_base[1:0] + 2'(m_beat));
    return {m_base[AW-1:2], lo};
  endfunction

  task automatic model_edge();
    if (rst) begin
      m_op = 0; m_pend = 0; m_beat = 0;
    end else if (clk_en) begin
      if (m_pend)
        for (int b = 0; b < NB; b++)
          if (m_pmask[b]) ref_mem[m_paddr][b*8 +: 8] = din[b*8 +: 8];
      m_pend = 0;
      if (sleep) m_op = 0;
      else if (!adv_ld) begin
        m_base = addr; m_beat = 0;
        m_op = (!sel0_n && sel1 && !sel2_n) ? (wr_en ? 2 : 1) : 0;
      end else if (m_op != 0) m_beat = (m_beat + 1) % 4;
      if (m_op == 2) begin m_pend = 1; m_paddr = m_eff(); m_pmask = byte_en; end
      if (m_op == 1) m_rd = ref_mem[m_eff()];
    end
  endtask

  task automatic compare();
    bit exp_oe;
    exp_oe = (m_op == 1) && oe && !sleep;
    vecs++;
    if (dout_oe !== exp_oe) begin
      fails++;
      $display("FAIL %s: dout_oe=%0b expected %0b at %0t", cur_req, dout_oe, exp_oe, $time);
    end else if (exp_oe && dout !== m_rd) begin
      fails++;
      $display("FAIL %s: dout=%h expected %h at %0t", cur_req, dout, m_rd, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
  endtask

  task automatic sel_on();
    sel0_n = 0; sel1 = 1; sel2_n = 0;
  endtask

  // set command inputs; din gets a fresh value each call
  task automatic cmd(input bit ld, input bit w, input int a, input logic [NB-1:0] be);
    adv_ld = !ld; wr_en = w; addr = AW'(a); byte_en = be; clk_en = 1;
    din = $urandom;
    step();
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run hung, expected completion");
      finish_run();
    end
  end

  initial begin
    // R13: reset state
    repeat (3) begin @(posedge clk); model_edge(); @(negedge clk); compare(); end
    rst = 0;
    sel_on();

    // R2 R4: fill all words with linear write bursts
    cur_req = "R2/R4 fill";
    mode_ilv = 0;
    for (int g = 0; g < (1<<AW)/4; g++)
      for (int k = 0; k < 4; k++) cmd(k == 0, 1, g*4, '1);
    cmd(1, 0, 0, '0);

    // R1 R4 R3: linear read burst from offset 1, wrapping past four beats
    cur_req = "R1/R3/R4 linear read";
    cmd(1, 0, 5, '0);
    for (int k = 0; k < 6; k++) cmd(0, 0, 0, '0);

    // R5: interleaved read from offset 2 and 3
    cur_req = "R5 interleaved read";
    mode_ilv = 1;
    cmd(1, 0, 6, '0);
    for (int k = 0; k < 3; k++) cmd(0, 0, 0, '0);
    cmd(1, 0, 11, '0);
    for (int k = 0; k < 3; k++) cmd(0, 0, 0, '0);

    // R5 R2: interleaved write burst then read back
    cur_req = "R5/R2 interleaved write";
    cmd(1, 1, 17, '1);
    for (int k = 0; k < 3; k++) cmd(0, 1, 0, '1);
    cmd(1, 0, 17, '0);
    for (int k = 0; k < 3; k++) cmd(0, 0, 0, '0);
    mode_ilv = 0;

    // R12 R7 R2: alternating write/read on one word, no idle
    cur_req = "R12/R7 turnaround";
    for (int k = 0; k < 6; k++) begin
      cmd(1, 1, 20 + (k % 2), '1);
      cmd(1, 0, 20 + (k % 2), '0);
    end
    cmd(1, 1, 22, 4'b0110);
    cmd(1, 0, 22, '0);

    // R6: partial and empty byte masks
    cur_req = "R6 byte mask";
    cmd(1, 1, 30, 4'b0101);
    cmd(1, 1, 31, 4'b0000);
    cmd(1, 0, 30, '0);
    cmd(1, 0, 31, '0);
    cmd(1, 1, 32, 4'b1000);
    cmd(0, 1, 0, 4'b0000);
    cmd(0, 1, 0, 4'b0011);
    cmd(1, 0, 32, '0);
    for (int k = 0; k < 3; k++) cmd(0, 0, 0, '0);

    // R9: stalls mid read burst and during a write data phase
    cur_req = "R9 stall";
    cmd(1, 0, 40, '0);
    clk_en = 0; din = $urandom; addr = 7; adv_ld = 0; wr_en = 1;
    repeat (3) step();
    cmd(0, 0, 0, '0);
    cmd(1, 1, 44, '1);
    clk_en = 0;
    repeat (2) begin din = $urandom; step(); end
    cmd(1, 0, 44, '0);
    cmd(1, 0, 45, '0);

    // R8: each select inactive in turn
    cur_req = "R8 select";
    sel0_n = 1; cmd(1, 0, 3, '0); cmd(1, 1, 3, '1); sel_on();
    sel1 = 0;   cmd(1, 0, 3, '0); cmd(0, 0, 0, '0); sel_on();
    sel2_n = 1; cmd(1, 1, 3, '1); cmd(1, 0, 3, '0); sel_on();
    cmd(1, 0, 3, '0);

    // R10: output enable gates drivers without a clock
    cur_req = "R10 output enable";
    cmd(1, 0, 9, '0);
    #1 oe = 0; #0.5;
    vecs++;
    if (dout_oe !== 1'b0) begin
      fails++; $display("FAIL R10: dout_oe=%0b expected 0", dout_oe);
    end
    cmd(0, 0, 0, '0);
    oe = 1; #0.5 compare();

    // R11: sleep with a pending write, then reads
    cur_req = "R11 sleep";
    cmd(1, 1, 50, '1);
    sleep = 1;
    cmd(1, 0, 50, '0);
    cmd(1, 0, 51, '0);
    cmd(0, 0, 0, '0);
    sleep = 0;
    cmd(1, 0, 50, '0);
    cmd(1, 0, 9, '0);
    sleep = 1; #0.5 compare();
    sleep = 0;

    // R1 R3 R6 R9 R12: mixed traffic
    cur_req = "R1/R3/R6/R9/R12 mixed";
    for (int k = 0; k < 3000; k++) begin
      mode_ilv = (k / 500) % 2;
      sleep    = ($urandom % 40) == 0;
      oe       = ($urandom % 16) != 0;
      if (($urandom % 8) == 0) begin clk_en = 0; din = $urandom; step(); end
      else cmd(($urandom % 3) == 0, $urandom % 2, $urandom, NB'($urandom));
    end

    done = 1;
    finish_run();
  end

endmodule